// File: doc/BRIEF.md
# Delayed Motor-Fault and Sealed Over-Temperature Alarm Pair

This block watches two plant conditions and raises one alarm flag for each. Both channels evaluate their inputs only on clock edges where the shared sample strobe `tick` is high. Between strobes, both flags and the internal state hold their values.

The motor channel compares the operator run switch with the starter's running feedback. A mismatch exists when the switch is on and the feedback is off. The mismatch must last for a programmable number of consecutive samples before the alarm asserts, so the normal travel time of the contactor never shows up as a fault.

The temperature channel compares an unsigned temperature word with a set-point; the usual set-point is 100. Any sample above the set-point latches the alarm. The latch is released only by the operator's start/reset strobe, and only at a sample where the temperature is already below the set-point.

Top module: `dual_alarm_unit`

## Requirements
- R1: The motor mismatch is `run_sw`=1 together with `run_fb`=0. The delay counter advances only at sampling edges (`tick`=1) where the mismatch is present.
- R2: With preset P≥1, `motor_alarm` goes high at the edge of the P-th consecutive sampled mismatch and stays low before that. P=0 behaves like P=1.
- R3: A sample without mismatch returns the counter to zero and drops `motor_alarm` at that edge. A mismatch that lasts fewer than P samples leaves the alarm low, and a later mismatch starts counting from zero again.
- R4: `overtemp_alarm` goes high at any sampling edge where `temp` > `setpoint` (unsigned). A sample equal to the set-point does not set it.
- R5: Once set, `overtemp_alarm` stays high while the temperature falls back, so a single-sample excursion stays latched.
- R6: `overtemp_alarm` clears only at a sampling edge where `op_reset`=1 and `temp` < `setpoint`. If the temperature at that sample is equal to or above the set-point, the alarm stays set.
- R7: When `tick`=0, both outputs hold their values, including when `op_reset` is pulsed without `tick`.
- R8: Synchronous active-high `rst` clears both alarms and the delay counter at the next edge.
- R9: The delay counter saturates at the preset, so a mismatch held much longer than the preset keeps `motor_alarm` high without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample strobe shared by both channels |
| run_sw | input | 1 | Motor run switch, 1 = on |
| run_fb | input | 1 | Starter running feedback, 1 = running |
| temp | input | TEMP_W | Unsigned temperature sample |
| setpoint | input | TEMP_W | Over-temperature limit |
| op_reset | input | 1 | Operator start/reset strobe, qualified by `tick` |
| delay_preset | input | CNT_W | On-delay length in samples |
| motor_alarm | output | 1 | Motor-fault alarm |
| overtemp_alarm | output | 1 | Sealed over-temperature alarm |

## Verification
Each output is a single register. A sample's effect therefore appears right after the rising edge at which `tick` was high, and the bench reads the flags at the following falling edge. Inputs are driven at a falling edge, `tick` is held for exactly one cycle, and the check follows that cycle's rising edge. A delay of P samples is verified by checking the flag after sample P−1 (still low) and after sample P (high). Hold behaviour is checked by idling several cycles without `tick` and confirming that the flags are unchanged.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int unsigned DEF_TEMP_W   = 16;
  localparam int unsigned DEF_CNT_W    = 16;
  localparam int unsigned DEF_SETPOINT = 100;

  typedef enum logic {SEAL_OPEN = 1'b0, SEAL_HELD = 1'b1} seal_e;
endpackage

// File: rtl/alarm_ondelay.sv
module alarm_ondelay #(
  parameter int unsigned CNT_W = alarm_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cond,
  input  logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] cnt_o,
  output logic             alarm_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // Next count: clears when the condition is gone, saturates at the preset.
  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] lim,
    input logic             active
  );
    if (!active)        return '0;
    else if (cur >= lim) return lim;
    else                return cur + ONE;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             alarm_q;

  always_comb cnt_nxt = next_count(cnt_q, preset, cond);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      alarm_q <= 1'b0;
    end else if (tick) begin
      cnt_q   <= cnt_nxt;
      alarm_q <= cond && (cnt_nxt >= preset);
    end
  end

  assign cnt_o   = cnt_q;
  assign alarm_o = alarm_q;
endmodule

// File: rtl/alarm_seal.sv
module alarm_seal (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic set_cond,
  input  logic clr_ok,
  input  logic strobe,
  output logic alarm_o
);
  import alarm_pkg::*;

  seal_e st_q;

  // Set wins over clear; clear needs strobe and a safe reading.
  function automatic seal_e next_seal(
    input seal_e cur,
    input logic  s,
    input logic  ok,
    input logic  stb
  );
    if (s)              return SEAL_HELD;
    else if (stb && ok) return SEAL_OPEN;
    else                return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)       st_q <= SEAL_OPEN;
    else if (tick) st_q <= next_seal(st_q, set_cond, clr_ok, strobe);
  end

  assign alarm_o = (st_q == SEAL_HELD);
endmodule

// File: rtl/dual_alarm_unit.sv
module dual_alarm_unit #(
  parameter int unsigned TEMP_W = alarm_pkg::DEF_TEMP_W,
  parameter int unsigned CNT_W  = alarm_pkg::DEF_CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              run_sw,
  input  logic              run_fb,
  input  logic [TEMP_W-1:0] temp,
  input  logic [TEMP_W-1:0] setpoint,
  input  logic              op_reset,
  input  logic [CNT_W-1:0]  delay_preset,
  output logic              motor_alarm,
  output logic              overtemp_alarm
);
  function automatic logic is_mismatch(input logic sw, input logic fb);
    return sw && !fb;
  endfunction

  function automatic logic is_above(input logic [TEMP_W-1:0] v, input logic [TEMP_W-1:0] lim);
    return v > lim;
  endfunction

  function automatic logic is_below(input logic [TEMP_W-1:0] v, input logic [TEMP_W-1:0] lim);
    return v < lim;
  endfunction

  // Named internal events, visible to the bound checker.
  logic             motor_mis;
  logic             temp_hi;
  logic             temp_lo;
  logic [CNT_W-1:0] delay_cnt;

  assign motor_mis = is_mismatch(run_sw, run_fb);
  assign temp_hi   = is_above(temp, setpoint);
  assign temp_lo   = is_below(temp, setpoint);

  alarm_ondelay #(.CNT_W(CNT_W)) u_motor (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .cond    (motor_mis),
    .preset  (delay_preset),
    .cnt_o   (delay_cnt),
    .alarm_o (motor_alarm)
  );

  alarm_seal u_temp (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .set_cond (temp_hi),
    .clr_ok   (temp_lo),
    .strobe   (op_reset),
    .alarm_o  (overtemp_alarm)
  );
endmodule

// File: rtl/dual_alarm_chk.sv
module dual_alarm_chk #(
  parameter int unsigned TEMP_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              run_sw,
  input logic              run_fb,
  input logic [TEMP_W-1:0] temp,
  input logic [TEMP_W-1:0] setpoint,
  input logic              op_reset,
  input logic [CNT_W-1:0]  delay_cnt,
  input logic              motor_alarm,
  input logic              overtemp_alarm
);
  p_motor_rise_needs_mismatch_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(motor_alarm) |-> $past(tick && run_sw && !run_fb));

  p_motor_drop_on_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && !(run_sw && !run_fb)) |=> (!motor_alarm && delay_cnt == '0));

  p_temp_sets_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && temp > setpoint) |=> overtemp_alarm);

  p_temp_sealed_r5: assert property (@(posedge clk) disable iff (rst)
    (overtemp_alarm && !(tick && op_reset)) |=> overtemp_alarm);

  p_temp_clear_cond_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(overtemp_alarm) |-> $past(tick && op_reset && temp < setpoint));

  p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(motor_alarm) && $stable(overtemp_alarm) && $stable(delay_cnt)));

  p_reset_clears_r8: assert property (@(posedge clk)
    rst |=> (!motor_alarm && !overtemp_alarm && delay_cnt == '0));
endmodule

bind dual_alarm_unit dual_alarm_chk #(.TEMP_W(TEMP_W), .CNT_W(CNT_W)) i_chk (
  .clk            (clk),
  .rst            (rst),
  .tick           (tick),
  .run_sw         (run_sw),
  .run_fb         (run_fb),
  .temp           (temp),
  .setpoint       (setpoint),
  .op_reset       (op_reset),
  .delay_cnt      (delay_cnt),
  .motor_alarm    (motor_alarm),
  .overtemp_alarm (overtemp_alarm)
);

// File: tb/test_dual_alarm_unit.sv
module test_dual_alarm_unit;
  localparam int unsigned TW = 16;
  localparam int unsigned CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic          run_sw = 1'b0;
  logic          run_fb = 1'b0;
  logic [TW-1:0] temp = '0;
  logic [TW-1:0] setpoint = 16'd100;
  logic          op_reset = 1'b0;
  logic [CW-1:0] delay_preset = 4'd3;
  logic          motor_alarm;
  logic          overtemp_alarm;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  dual_alarm_unit #(.TEMP_W(TW), .CNT_W(CW)) i_dual_alarm_unit (
    .clk(clk), .rst(rst), .tick(tick), .run_sw(run_sw), .run_fb(run_fb),
    .temp(temp), .setpoint(setpoint), .op_reset(op_reset),
    .delay_preset(delay_preset), .motor_alarm(motor_alarm),
    .overtemp_alarm(overtemp_alarm)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input logic act, input logic exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // One sample: tick high for exactly one rising edge, read after it.
  task automatic sample();
    tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    idle(1);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check(motor_alarm, 1'b0, "R8 motor after reset");
    check(overtemp_alarm, 1'b0, "R8 temp after reset");
  endtask

  task automatic t_motor_delay();
    delay_preset = 4'd3; run_sw = 1'b1; run_fb = 1'b0;
    sample(); sample();
    check(motor_alarm, 1'b0, "R2 motor before preset");
    sample();
    check(motor_alarm, 1'b1, "R2 motor at preset");
    run_fb = 1'b1;
    sample();
    check(motor_alarm, 1'b0, "R3 motor drops when running");
  endtask

  task automatic t_motor_short();
    delay_preset = 4'd3; run_sw = 1'b1; run_fb = 1'b0;
    sample(); sample();
    run_sw = 1'b0;
    sample();
    check(motor_alarm, 1'b0, "R3 short mismatch no alarm");
    run_sw = 1'b1;
    sample(); sample();
    check(motor_alarm, 1'b0, "R3 count restarted from zero");
    sample();
    check(motor_alarm, 1'b1, "R3 fires after full restart");
    run_sw = 1'b0; sample();
  endtask

  task automatic t_motor_no_tick();
    delay_preset = 4'd1; run_sw = 1'b1; run_fb = 1'b0;
    idle(10);
    check(motor_alarm, 1'b0, "R1 no count without tick");
    run_fb = 1'b1; run_sw = 1'b1;
    sample();
    check(motor_alarm, 1'b0, "R1 switch on with feedback is no fault");
    run_sw = 1'b0; run_fb = 1'b0;
    sample();
    check(motor_alarm, 1'b0, "R1 switch off is no fault");
  endtask

  task automatic t_motor_preset0();
    delay_preset = 4'd0; run_sw = 1'b1; run_fb = 1'b0;
    sample();
    check(motor_alarm, 1'b1, "R2 preset zero fires first sample");
    run_sw = 1'b0; sample();
  endtask

  task automatic t_motor_saturate();
    delay_preset = 4'd15; run_sw = 1'b1; run_fb = 1'b0;
    for (int i = 0; i < 14; i++) sample();
    check(motor_alarm, 1'b0, "R2 preset 15 one sample short");
    sample();
    check(motor_alarm, 1'b1, "R2 preset 15 reached");
    for (int i = 0; i < 20; i++) sample();
    check(motor_alarm, 1'b1, "R9 saturated count keeps alarm");
    run_fb = 1'b0; run_sw = 1'b1;
    idle(4);
    check(motor_alarm, 1'b1, "R7 motor holds between samples");
    run_sw = 1'b0; sample();
  endtask

  task automatic t_temp_set();
    setpoint = 16'd100; temp = 16'd100;
    sample();
    check(overtemp_alarm, 1'b0, "R4 equal does not set");
    temp = 16'd101;
    sample();
    check(overtemp_alarm, 1'b1, "R4 above sets");
    temp = 16'd40;
    sample(); sample();
    check(overtemp_alarm, 1'b1, "R5 sealed after excursion");
  endtask

  task automatic t_temp_reset();
    temp = 16'd40; op_reset = 1'b1;
    idle(3);
    op_reset = 1'b0;
    check(overtemp_alarm, 1'b1, "R7 strobe without tick ignored");
    temp = 16'd100; op_reset = 1'b1;
    sample();
    check(overtemp_alarm, 1'b1, "R6 reset at set-point blocked");
    temp = 16'd150;
    sample();
    check(overtemp_alarm, 1'b1, "R6 reset while high blocked");
    temp = 16'd99;
    sample();
    op_reset = 1'b0;
    check(overtemp_alarm, 1'b0, "R6 reset below clears");
    temp = 16'd150;
    idle(3);
    check(overtemp_alarm, 1'b0, "R7 no set without tick");
    temp = 16'd40;
  endtask

  task automatic t_mid_reset();
    delay_preset = 4'd1; run_sw = 1'b1; run_fb = 1'b0; temp = 16'd200;
    sample();
    check(motor_alarm, 1'b1, "R2 preset one fires");
    check(overtemp_alarm, 1'b1, "R4 set before reset");
    temp = 16'd10; run_sw = 1'b0;
    do_reset();
    check(motor_alarm, 1'b0, "R8 motor cleared");
    check(overtemp_alarm, 1'b0, "R8 temp cleared");
  endtask

  initial begin
    idle(2);
    t_reset_state();
    t_motor_delay();
    t_motor_short();
    t_motor_no_tick();
    t_motor_preset0();
    t_motor_saturate();
    t_temp_set();
    t_temp_reset();
    t_mid_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule